// File: doc/BRIEF.md
# Correlation Channel Register File and Run Sequencer

This block is the host-facing control point of one correlation channel. It holds a bank of sixteen 32-bit words. The host writes loop settings into them: the code step, the integration and code lengths, the carrier phase and step, the sample skip count, and the start chip index and start fraction of each tap. The block drives these settings to the correlator datapath as plain outputs. It also forwards commands for the code memory, holds a channel lock that gates sample flow, and provides a scratch word that the host can use to test the bus.

Any write to the launch word starts a correlation run while the channel is idle. The block then waits for the datapath to report completion. At completion it captures the per-tap real and imaginary sums and raises an interrupt. The tap words are shared between settings and results. A write to one of them sets a start parameter, and a read from it returns the captured sum. The interrupt stays raised until the host acknowledges it or launches the next run.

Top module: `trk_chan_regs`

## Requirements
- R1: After reset, `irq`, `run_start`, `code_cmd_vld` and `samples_pass` are 0, and every readable word returns 0.
- R2: Word 15 is a scratch word. Any 32-bit value written to it reads back unchanged. `rd_data` is valid in the cycle after the cycle in which `rd_en` is sampled.
- R3: Words 0 (code step), 7 (integration length minus one), 8 (code length minus one), 9 (carrier phase), 10 (carrier step) and 13 (sample skip count) store the written value. Each drives its output from the cycle after the write, and each reads back the stored value.
- R4: With N = `NTAPS` (at most 3), a write to word 1+k sets the start chip index of tap k (`tap_index` bits [32k+31:32k]). A write to word N+1+k sets the start fraction of tap k (`tap_frac` in the same bit slice).
- R5: A read of word 1+k returns the real result of tap k captured at the last completion. A read of word N+1+k returns the imaginary result of tap k. Each result is `RES_W` bits wide, zero-extended, and taken from slice [RES_W·k +: RES_W] of `res_re` or `res_im`. These reads never return the start values that were written to the same words.
- R6: A write to word 11 produces a one-cycle `code_cmd_vld` pulse in the following cycle, with `code_cmd_data` equal to the written data. Word 11 reads as 0.
- R7: Bit 0 of a write to word 12 sets the channel lock. A value of 0 holds `samples_pass` at 0 (locked), and a value of 1 sets it to 1 (unlocked). Word 12 reads back that bit.
- R8: A write of any data to word 14 while idle produces `run_start` high for exactly the one cycle that follows the write.
- R9: A write to word 14 while a run is active is ignored: no `run_start` pulse, and the run continues.
- R10: `corr_done` while a run is active ends the run, captures the results, and sets `irq` in the following cycle. `corr_done` while idle changes nothing.
- R11: `irq` stays high until an `irq_ack` pulse or an accepted launch clears it. In either case it is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write word address |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Host read word address |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| irq_ack | input | 1 | Interrupt acknowledge (re-enable) pulse |
| irq | output | 1 | Run-complete interrupt |
| code_step | output | 32 | Code phase step |
| integ_len_m1 | output | 32 | Integration length minus one |
| code_len_m1 | output | 32 | Code length minus one |
| carr_phase | output | 32 | Initial carrier phase |
| carr_step | output | 32 | Carrier phase step |
| skip_count | output | 32 | Initial sample skip count |
| tap_index | output | 32·NTAPS | Per-tap start chip index |
| tap_frac | output | 32·NTAPS | Per-tap start fraction |
| code_cmd_vld | output | 1 | Code memory command strobe |
| code_cmd_data | output | 32 | Code memory command word |
| samples_pass | output | 1 | 1 when the channel is unlocked |
| run_start | output | 1 | One-cycle run launch pulse |
| corr_done | input | 1 | Datapath completion pulse |
| res_re | input | RES_W·NTAPS | Per-tap real results |
| res_im | input | RES_W·NTAPS | Per-tap imaginary results |

## Verification
The results arrive with fixed latencies. A setting output and the `code_cmd_vld` strobe change in the cycle after the write edge. `run_start` is high in the cycle after an accepted launch and low in the cycle after that. `irq` follows the completion edge or the clearing edge by one cycle. `rd_data` lags `rd_en` by one cycle. The bench drives each stimulus on a falling edge and samples the outputs on the next falling edge, after exactly one rising edge. Read expectations go into a queue. A monitor pops each one on the falling edge that follows the rising edge at which the read strobe was seen.

// File: rtl/trk_regs_pkg.sv
package trk_regs_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;

    // Word addresses whose position is decoded by host software
    localparam logic [ADDR_W-1:0] A_CODE_STEP = 4'd0;
    localparam logic [ADDR_W-1:0] A_TAP_BASE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_INTEG     = 4'd7;
    localparam logic [ADDR_W-1:0] A_CODE_LEN  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CARR_PH   = 4'd9;
    localparam logic [ADDR_W-1:0] A_CARR_STEP = 4'd10;
    localparam logic [ADDR_W-1:0] A_CODE_CMD  = 4'd11;
    localparam logic [ADDR_W-1:0] A_LOCK      = 4'd12;
    localparam logic [ADDR_W-1:0] A_SKIP      = 4'd13;
    localparam logic [ADDR_W-1:0] A_LAUNCH    = 4'd14;
    localparam logic [ADDR_W-1:0] A_SCRATCH   = 4'd15;

    typedef struct packed {
        logic code_step;
        logic integ;
        logic code_len;
        logic carr_ph;
        logic carr_step;
        logic code_cmd;
        logic lock;
        logic skip;
        logic launch;
        logic scratch;
    } wr_strb_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    function automatic logic [ADDR_W-1:0] tap_idx_addr(input int k);
        return ADDR_W'(int'(A_TAP_BASE) + k);
    endfunction

    function automatic logic [ADDR_W-1:0] tap_frac_addr(input int k, input int n);
        return ADDR_W'(int'(A_TAP_BASE) + n + k);
    endfunction

endpackage

// File: rtl/trk_wr_decode.sv
module trk_wr_decode
    import trk_regs_pkg::*;
#(
    parameter int NTAPS = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_strb_t          strb,
    output logic [NTAPS-1:0]  idx_we,
    output logic [NTAPS-1:0]  frac_we
);

    always_comb begin
        strb.code_step = wr_en && (wr_addr == A_CODE_STEP);
        strb.integ     = wr_en && (wr_addr == A_INTEG);
        strb.code_len  = wr_en && (wr_addr == A_CODE_LEN);
        strb.carr_ph   = wr_en && (wr_addr == A_CARR_PH);
        strb.carr_step = wr_en && (wr_addr == A_CARR_STEP);
        strb.code_cmd  = wr_en && (wr_addr == A_CODE_CMD);
        strb.lock      = wr_en && (wr_addr == A_LOCK);
        strb.skip      = wr_en && (wr_addr == A_SKIP);
        strb.launch    = wr_en && (wr_addr == A_LAUNCH);
        strb.scratch   = wr_en && (wr_addr == A_SCRATCH);
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap_dec
        assign idx_we[k]  = wr_en && (wr_addr == tap_idx_addr(k));
        assign frac_we[k] = wr_en && (wr_addr == tap_frac_addr(k, NTAPS));
    end

endmodule

// File: rtl/trk_sequencer.sv
module trk_sequencer
    import trk_regs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch_we,
    input  logic corr_done,
    input  logic irq_ack,
    output logic run_start,
    output logic busy,
    output logic capture,
    output logic irq
);

    seq_state_t state;

    assign busy    = (state == SEQ_RUN);
    assign capture = busy && corr_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            run_start <= 1'b0;
            irq       <= 1'b0;
        end else begin
            run_start <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (launch_we) begin
                        state     <= SEQ_RUN;
                        run_start <= 1'b1;
                        irq       <= 1'b0;
                    end else if (irq_ack) begin
                        irq <= 1'b0;
                    end
                end
                SEQ_RUN: begin
                    if (corr_done) begin
                        state <= SEQ_IDLE;
                        irq   <= 1'b1;
                    end else if (irq_ack) begin
                        irq <= 1'b0;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trk_result_bank.sv
module trk_result_bank #(
    parameter int NTAPS = 3,
    parameter int RES_W = 21
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture,
    input  logic [NTAPS*RES_W-1:0] re_in,
    input  logic [NTAPS*RES_W-1:0] im_in,
    output logic [NTAPS*RES_W-1:0] re_q,
    output logic [NTAPS*RES_W-1:0] im_q
);

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap_res
        always_ff @(posedge clk) begin
            if (rst) begin
                re_q[k*RES_W +: RES_W] <= '0;
                im_q[k*RES_W +: RES_W] <= '0;
            end else if (capture) begin
                re_q[k*RES_W +: RES_W] <= re_in[k*RES_W +: RES_W];
                im_q[k*RES_W +: RES_W] <= im_in[k*RES_W +: RES_W];
            end
        end
    end

endmodule

// File: rtl/trk_chan_regs.sv
module trk_chan_regs
    import trk_regs_pkg::*;
#(
    parameter int NTAPS = 3,
    parameter int RES_W = 21
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [3:0]               wr_addr,
    input  logic [31:0]              wr_data,
    input  logic                     rd_en,
    input  logic [3:0]               rd_addr,
    output logic [31:0]              rd_data,
    input  logic                     irq_ack,
    output logic                     irq,
    output logic [31:0]              code_step,
    output logic [31:0]              integ_len_m1,
    output logic [31:0]              code_len_m1,
    output logic [31:0]              carr_phase,
    output logic [31:0]              carr_step,
    output logic [31:0]              skip_count,
    output logic [NTAPS*32-1:0]      tap_index,
    output logic [NTAPS*32-1:0]      tap_frac,
    output logic                     code_cmd_vld,
    output logic [31:0]              code_cmd_data,
    output logic                     samples_pass,
    output logic                     run_start,
    input  logic                     corr_done,
    input  logic [NTAPS*RES_W-1:0]   res_re,
    input  logic [NTAPS*RES_W-1:0]   res_im
);

    localparam int RES_V = NTAPS * RES_W;

    wr_strb_t         strb;
    logic [NTAPS-1:0] idx_we;
    logic [NTAPS-1:0] frac_we;
    logic             busy_w;
    logic             capture_w;
    logic [RES_V-1:0] re_q;
    logic [RES_V-1:0] im_q;
    logic [31:0]      scratch_q;
    logic [31:0]      rd_mux;

    trk_wr_decode #(.NTAPS(NTAPS)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .strb    (strb),
        .idx_we  (idx_we),
        .frac_we (frac_we)
    );

    trk_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch_we (strb.launch),
        .corr_done (corr_done),
        .irq_ack   (irq_ack),
        .run_start (run_start),
        .busy      (busy_w),
        .capture   (capture_w),
        .irq       (irq)
    );

    trk_result_bank #(.NTAPS(NTAPS), .RES_W(RES_W)) u_res (
        .clk     (clk),
        .rst     (rst),
        .capture (capture_w),
        .re_in   (res_re),
        .im_in   (res_im),
        .re_q    (re_q),
        .im_q    (im_q)
    );

    // Setting words
    always_ff @(posedge clk) begin
        if (rst) begin
            code_step     <= '0;
            integ_len_m1  <= '0;
            code_len_m1   <= '0;
            carr_phase    <= '0;
            carr_step     <= '0;
            skip_count    <= '0;
            scratch_q     <= '0;
            samples_pass  <= 1'b0;
            code_cmd_vld  <= 1'b0;
            code_cmd_data <= '0;
        end else begin
            code_cmd_vld <= strb.code_cmd;
            if (strb.code_cmd)  code_cmd_data <= wr_data;
            if (strb.code_step) code_step     <= wr_data;
            if (strb.integ)     integ_len_m1  <= wr_data;
            if (strb.code_len)  code_len_m1   <= wr_data;
            if (strb.carr_ph)   carr_phase    <= wr_data;
            if (strb.carr_step) carr_step     <= wr_data;
            if (strb.skip)      skip_count    <= wr_data;
            if (strb.scratch)   scratch_q     <= wr_data;
            if (strb.lock)      samples_pass  <= wr_data[0];
        end
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                tap_index[k*32 +: 32] <= '0;
                tap_frac[k*32 +: 32]  <= '0;
            end else begin
                if (idx_we[k])  tap_index[k*32 +: 32] <= wr_data;
                if (frac_we[k]) tap_frac[k*32 +: 32]  <= wr_data;
            end
        end
    end

    // Read path: tap words return captured results
    always_comb begin
        case (rd_addr)
            A_CODE_STEP: rd_mux = code_step;
            A_INTEG:     rd_mux = integ_len_m1;
            A_CODE_LEN:  rd_mux = code_len_m1;
            A_CARR_PH:   rd_mux = carr_phase;
            A_CARR_STEP: rd_mux = carr_step;
            A_LOCK:      rd_mux = {31'd0, samples_pass};
            A_SKIP:      rd_mux = skip_count;
            A_SCRATCH:   rd_mux = scratch_q;
            default:     rd_mux = '0;
        endcase
        for (int k = 0; k < NTAPS; k++) begin
            if (rd_addr == tap_idx_addr(k))
                rd_mux = 32'(re_q[k*RES_W +: RES_W]);
            if (rd_addr == tap_frac_addr(k, NTAPS))
                rd_mux = 32'(im_q[k*RES_W +: RES_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

endmodule

// File: rtl/trk_chan_regs_chk.sv
module trk_chan_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        irq_ack,
    input logic        corr_done,
    input logic        run_start,
    input logic        irq,
    input logic        code_cmd_vld,
    input logic [31:0] code_cmd_data,
    input logic        busy
);

    logic launch_w;
    assign launch_w = wr_en && (wr_addr == 4'd14);

    assert_cmd_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 4'd11) |=> (code_cmd_vld && code_cmd_data == $past(wr_data)));

    assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
        run_start |=> !run_start);

    assert_launch_starts_R8: assert property (@(posedge clk) disable iff (rst)
        (launch_w && !busy) |=> run_start);

    assert_busy_launch_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (launch_w && busy) |=> !run_start);

    assert_irq_from_done_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(corr_done && busy));

    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !(corr_done && busy)) |=> !irq);

    assert_launch_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (launch_w && !busy) |=> !irq);

endmodule

bind trk_chan_regs trk_chan_regs_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .irq_ack       (irq_ack),
    .corr_done     (corr_done),
    .run_start     (run_start),
    .irq           (irq),
    .code_cmd_vld  (code_cmd_vld),
    .code_cmd_data (code_cmd_data),
    .busy          (busy_w)
);

// File: tb/sim_trk_chan_regs.sv
`timescale 1ns/1ps
module sim_trk_chan_regs;

    localparam int NT = 3;
    localparam int RW = 21;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic irq_ack = 1'b0;
    logic irq;
    logic [31:0] code_step, integ_len_m1, code_len_m1, carr_phase, carr_step, skip_count;
    logic [NT*32-1:0] tap_index, tap_frac;
    logic code_cmd_vld;
    logic [31:0] code_cmd_data;
    logic samples_pass;
    logic run_start;
    logic corr_done = 1'b0;
    logic [NT*RW-1:0] res_re = '0;
    logic [NT*RW-1:0] res_im = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic rd_pend = 1'b0;

    always #10 clk = ~clk;

    trk_chan_regs #(.NTAPS(NT), .RES_W(RW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq),
        .code_step(code_step), .integ_len_m1(integ_len_m1), .code_len_m1(code_len_m1),
        .carr_phase(carr_phase), .carr_step(carr_step), .skip_count(skip_count),
        .tap_index(tap_index), .tap_frac(tap_frac), .code_cmd_vld(code_cmd_vld),
        .code_cmd_data(code_cmd_data), .samples_pass(samples_pass), .run_start(run_start),
        .corr_done(corr_done), .res_re(res_re), .res_im(res_im)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: rd_data is due one edge after rd_en was sampled
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                chk(rd_data, 32'hxxxx_xxxx, "scoreboard underflow");
            end else begin
                chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run(input logic [NT*RW-1:0] re, input logic [NT*RW-1:0] im);
        @(negedge clk);
        corr_done = 1'b1; res_re = re; res_im = im;
        @(negedge clk);
        corr_done = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    localparam logic [NT*RW-1:0] RE_A = {21'h100000, 21'h000123, 21'h1FFFFB};
    localparam logic [NT*RW-1:0] IM_A = {21'h000001, 21'h1FFFFF, 21'h0ABCDE};
    localparam logic [NT*RW-1:0] RE_B = {21'h000777, 21'h000666, 21'h000555};
    localparam logic [NT*RW-1:0] IM_B = {21'h000AAA, 21'h000999, 21'h000888};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk({31'd0, irq}, 32'd0, "R1 irq");
        chk({31'd0, run_start}, 32'd0, "R1 run_start");
        chk({31'd0, code_cmd_vld}, 32'd0, "R1 code_cmd_vld");
        chk({31'd0, samples_pass}, 32'd0, "R1 samples_pass");
        bus_rd(4'd15, 32'd0, "R1 scratch after reset");
        bus_rd(4'd1, 32'd0, "R1 tap word after reset");
        bus_rd(4'd9, 32'd0, "R1 carrier phase after reset");

        // R2 scratch
        bus_wr(4'd15, 32'h0000_55AA);
        bus_rd(4'd15, 32'h0000_55AA, "R2 scratch 55AA");
        bus_wr(4'd15, 32'hFFFF_FFFF);
        bus_rd(4'd15, 32'hFFFF_FFFF, "R2 scratch ones");

        // R3 setting words
        bus_wr(4'd0, 32'h0004_1893);
        chk(code_step, 32'h0004_1893, "R3 code_step out");
        bus_wr(4'd7, 32'd3999);
        chk(integ_len_m1, 32'd3999, "R3 integ out");
        bus_wr(4'd8, 32'd1022);
        chk(code_len_m1, 32'd1022, "R3 code_len out");
        bus_wr(4'd9, 32'hC000_0000);
        chk(carr_phase, 32'hC000_0000, "R3 carr_phase out");
        bus_wr(4'd10, 32'h0123_4567);
        chk(carr_step, 32'h0123_4567, "R3 carr_step out");
        bus_wr(4'd13, 32'd250);
        chk(skip_count, 32'd250, "R3 skip out");
        bus_rd(4'd0, 32'h0004_1893, "R3 read code_step");
        bus_rd(4'd7, 32'd3999, "R3 read integ");
        bus_rd(4'd8, 32'd1022, "R3 read code_len");
        bus_rd(4'd9, 32'hC000_0000, "R3 read carr_phase");
        bus_rd(4'd10, 32'h0123_4567, "R3 read carr_step");
        bus_rd(4'd13, 32'd250, "R3 read skip");

        // R4 tap start parameters
        for (int k = 0; k < NT; k++) begin
            bus_wr(4'(1 + k), 32'd100 + 32'(k));
            bus_wr(4'(1 + NT + k), 32'h000A_0000 + 32'(k));
        end
        for (int k = 0; k < NT; k++) begin
            chk(tap_index[k*32 +: 32], 32'd100 + 32'(k), "R4 tap_index");
            chk(tap_frac[k*32 +: 32], 32'h000A_0000 + 32'(k), "R4 tap_frac");
        end
        // R5 tap reads show results, not written starts
        bus_rd(4'd1, 32'd0, "R5 tap0 real before run");
        bus_rd(4'd4, 32'd0, "R5 tap0 imag before run");

        // R6 code command port
        bus_wr(4'd11, 32'h0C00_0001);
        chk({31'd0, code_cmd_vld}, 32'd1, "R6 cmd strobe");
        chk(code_cmd_data, 32'h0C00_0001, "R6 cmd data");
        @(negedge clk);
        chk({31'd0, code_cmd_vld}, 32'd0, "R6 cmd strobe one cycle");
        bus_rd(4'd11, 32'd0, "R6 cmd word reads zero");

        // R7 lock
        bus_wr(4'd12, 32'd1);
        chk({31'd0, samples_pass}, 32'd1, "R7 unlock");
        bus_rd(4'd12, 32'd1, "R7 read unlocked");
        bus_wr(4'd12, 32'd2);
        chk({31'd0, samples_pass}, 32'd0, "R7 bit0 only locks");
        bus_wr(4'd12, 32'd0);
        chk({31'd0, samples_pass}, 32'd0, "R7 lock");
        bus_rd(4'd12, 32'd0, "R7 read locked");

        // R8 launch
        bus_wr(4'd14, 32'hDEAD_BEEF);
        chk({31'd0, run_start}, 32'd1, "R8 run_start pulse");
        @(negedge clk);
        chk({31'd0, run_start}, 32'd0, "R8 run_start single");
        // R9 launch while busy
        bus_wr(4'd14, 32'd0);
        chk({31'd0, run_start}, 32'd0, "R9 busy launch ignored");
        chk({31'd0, irq}, 32'd0, "R10 no irq before done");

        // R10 completion
        finish_run(RE_A, IM_A);
        chk({31'd0, irq}, 32'd1, "R10 irq on done");
        bus_rd(4'd1, 32'h001F_FFFB, "R5 tap0 real");
        bus_rd(4'd2, 32'h0000_0123, "R5 tap1 real");
        bus_rd(4'd3, 32'h0010_0000, "R5 tap2 real");
        bus_rd(4'd4, 32'h000A_BCDE, "R5 tap0 imag");
        bus_rd(4'd5, 32'h001F_FFFF, "R5 tap1 imag");
        bus_rd(4'd6, 32'h0000_0001, "R5 tap2 imag");

        // R11 irq holds until ack
        repeat (5) @(negedge clk);
        chk({31'd0, irq}, 32'd1, "R11 irq held");
        ack();
        chk({31'd0, irq}, 32'd0, "R11 ack clears");

        // R10 done while idle ignored
        finish_run(RE_B, IM_B);
        chk({31'd0, irq}, 32'd0, "R10 idle done no irq");
        bus_rd(4'd1, 32'h001F_FFFB, "R10 idle done no capture");

        // R11 launch clears irq
        bus_wr(4'd14, 32'd1);
        chk({31'd0, run_start}, 32'd1, "R8 second launch");
        finish_run(RE_B, IM_B);
        chk({31'd0, irq}, 32'd1, "R10 second irq");
        bus_rd(4'd3, 32'h0000_0777, "R5 second run tap2 real");
        bus_wr(4'd14, 32'd5);
        chk({31'd0, irq}, 32'd0, "R11 launch clears irq");
        chk({31'd0, run_start}, 32'd1, "R8 third launch");
        finish_run(RE_A, IM_A);
        chk({31'd0, irq}, 32'd1, "R10 third irq");
        chk(tap_index[0 +: 32], 32'd100, "R4 start unchanged by results");

        repeat (3) @(negedge clk);
        chk(32'(exp_q.size()), 32'd0, "scoreboard drained");
        summary();
    end

endmodule